// File: doc/BRIEF.md
# Indexed Absolute Read Sequencer

This block runs the bus-cycle sequence of an 8-bit processor's absolute read with an index register added. It takes a start strobe, the address of the instruction and the index value, and then drives a byte-wide memory read port. It reads three instruction bytes in turn: the opcode and the low and high halves of the base address. It adds the index to the low half while the high half is being read. It then reads the data byte.

The first data read goes out right away at the fetched high byte joined with the 8-bit sum. This read is speculative and is not held back until the carry is known. When the index sum carries out of the low byte, that byte is thrown away. The high byte is incremented and a fifth bus cycle reads the corrected address. The instruction therefore takes 4 bus cycles when the data address stays in the base page and 5 when it crosses into the next one. Where the instruction bytes themselves sit in memory has no effect on the count.

When the sequence ends, the block raises a one-clock done pulse. At the same time it presents the loaded byte, the number of bus cycles used and the advanced program counter.

Top module: `idx_abs_reader`

## Requirements
- R1: After reset, mem_rd, done, data_out, cycles and pc_out are all zero.
- R2: A start seen high while idle begins the sequence on the next clock. The first three bus cycles read pc_in, pc_in+1 and pc_in+2 (16-bit wrap) on consecutive clocks with mem_rd high.
- R3: The fourth bus cycle reads address {high operand byte, (low operand byte + index) mod 256}, whether or not the sum carried.
- R4: When the low byte plus the index is below 256, the sequence ends after 4 reads. done then rises with cycles = 4 and data_out equal to the byte returned by the fourth read.
- R5: When the low byte plus the index is 256 or more, a fifth read follows at {high byte + 1, sum low byte}. done then rises with cycles = 5 and data_out equal to the fifth read's byte; the fourth read's byte is discarded.
- R6: The cycle count depends only on the index carry, even when the opcode or operand bytes straddle a page boundary or the top of memory.
- R7: While done is high, pc_out equals the instruction address plus 3 (mod 65536).
- R8: done is high for exactly one clock per instruction, and mem_rd is low in that clock.
- R9: A start asserted while a sequence is running is ignored. The read addresses are unchanged and the block is idle, with mem_rd low, in the clock after done.
- R10: A high byte of 0xFF with a carry produces a corrected read in page 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| pc_in | input | 16 | Address of the opcode |
| index | input | 8 | Index register value |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as mem_addr |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Read strobe, high in every bus cycle of the sequence |
| data_out | output | 8 | Loaded data byte |
| done | output | 1 | One-clock completion pulse |
| cycles | output | 3 | Bus cycles used by the last instruction (4 or 5) |
| pc_out | output | 16 | Program counter, advanced once per instruction byte |

## Verification
The bench builds the block with its default byte width of 8, which gives a 16-bit address. The whole address space, including the wrap of the program counter past 0xFFFF and of the corrected page past 0xFF, can therefore be driven directly. Random bases and indexes reach both the carry and no-carry cases. Directed cases place the instruction at 0x03FE, 0x03FF and 0xFFFE, use the 0x03F0 base with indexes 0x2A and 0x02, and pulse start while a sequence is running.

// File: rtl/idx_abs_reader.sv
module idx_abs_reader #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2*BYTE_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0]     index,
  input  logic [BYTE_W-1:0]     mem_rdata,
  output logic [2*BYTE_W-1:0]   mem_addr,
  output logic                  mem_rd,
  output logic [BYTE_W-1:0]     data_out,
  output logic                  done,
  output logic [2:0]            cycles,
  output logic [2*BYTE_W-1:0]   pc_out
);
  localparam int AW = 2 * BYTE_W;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_OPC = 3'd1, S_LO = 3'd2, S_HI = 3'd3, S_RD = 3'd4, S_FIX = 3'd5
  } st_t;

  st_t               st;
  logic [AW-1:0]     pc_q;
  logic [BYTE_W-1:0] idx_q, lo_q, hi_q;
  logic              carry_q;
  logic [BYTE_W:0]   sum;

  assign sum    = {1'b0, lo_q} + {1'b0, idx_q};
  assign mem_rd = (st != S_IDLE);
  assign pc_out = pc_q;

  always_comb begin
    case (st)
      S_RD:    mem_addr = {hi_q, lo_q};
      S_FIX:   mem_addr = {hi_q + BYTE_W'(1), lo_q};
      default: mem_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pc_q     <= '0;
      idx_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      carry_q  <= 1'b0;
      data_out <= '0;
      done     <= 1'b0;
      cycles   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pc_q  <= pc_in;
          idx_q <= index;
          st    <= S_OPC;
        end
        S_OPC: begin
          pc_q <= pc_q + AW'(1);
          st   <= S_LO;
        end
        S_LO: begin
          lo_q <= mem_rdata;
          pc_q <= pc_q + AW'(1);
          st   <= S_HI;
        end
        S_HI: begin
          hi_q    <= mem_rdata;
          lo_q    <= sum[BYTE_W-1:0];
          carry_q <= sum[BYTE_W];
          pc_q    <= pc_q + AW'(1);
          st      <= S_RD;
        end
        S_RD: begin
          if (carry_q) begin
            st <= S_FIX;
          end else begin
            data_out <= mem_rdata;
            cycles   <= 3'd4;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_FIX: begin
          data_out <= mem_rdata;
          cycles   <= 3'd5;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_abs_reader_chk.sv
module idx_abs_reader_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_rd,
  input logic          done,
  input logic [2:0]    st,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] pc_out,
  input logic [2:0]    cycles
);
  localparam int HB = AW / 2;

  AST_OPERAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R2
  AST_FIX_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |-> (mem_addr == {$past(mem_addr[AW-1:HB]) + HB'(1), $past(mem_addr[HB-1:0])})); // R5
  AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles == 3'd4 || cycles == 3'd5)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4) |-> (pc_out == $past(pc_out) + AW'(1))); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mem_rd && st != 3'd0) |=> (st != 3'd1)); // R9
endmodule

bind idx_abs_reader idx_abs_reader_chk #(.AW(2*BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .done(done),
  .st(st), .mem_addr(mem_addr), .pc_out(pc_out), .cycles(cycles)
);

// File: tb/idx_abs_reader_bench.sv
module idx_abs_reader_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  index = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  data_out;
  logic        done;
  logic [2:0]  cycles;
  logic [15:0] pc_out;

  int total = 0;
  int bad = 0;

  logic [15:0] ipc = 16'h0000;
  logic [7:0]  ilo = 8'h00;
  logic [7:0]  ihi = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    if (a == ipc)                return 8'hBD;
    if (a == ipc + 16'd1)        return ilo;
    if (a == ipc + 16'd2)        return ihi;
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  idx_abs_reader u_idx_abs_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .index(index),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .data_out(data_out), .done(done), .cycles(cycles), .pc_out(pc_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_instr(input logic [15:0] pc, input logic [7:0] lo,
                           input logic [7:0] hi, input logic [7:0] idx,
                           input bit poke, input string req);
    logic [15:0] addrs [0:7];
    int          n = 0;
    bit          seen = 0;
    logic [8:0]  s;
    logic [15:0] spec, fixd, fin;
    int          exp_n;
    ipc = pc; ilo = lo; ihi = hi;
    s     = {1'b0, lo} + {1'b0, idx};
    spec  = {hi, s[7:0]};
    fixd  = {hi + 8'd1, s[7:0]};
    exp_n = s[8] ? 5 : 4;
    fin   = s[8] ? fixd : spec;
    @(negedge clk);
    start = 1'b1; pc_in = pc; index = idx;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (done) begin seen = 1; break; end
      if (mem_rd && n < 8) begin addrs[n] = mem_addr; n++; end
      if (poke && k == 1) begin start = 1'b1; pc_in = 16'h1234; index = 8'hFF; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(seen, req, "done seen", int'(seen), 1);
    chk(n == exp_n, "R4/R5", "read count", n, exp_n);
    for (int j = 0; j < 3; j++)
      if (j < n) chk(addrs[j] == pc + 16'(j), "R2", "fetch addr", addrs[j], pc + 16'(j));
    if (n > 3) chk(addrs[3] == spec, "R3", "spec addr", addrs[3], spec);
    if (s[8] && n > 4) chk(addrs[4] == fixd, "R5", "fix addr", addrs[4], fixd);
    chk(cycles == 3'(exp_n), req, "cycles", cycles, exp_n);
    chk(data_out == mem_f(fin), req, "data", data_out, mem_f(fin));
    chk(pc_out == pc + 16'd3, "R7", "pc end", pc_out, pc + 16'd3);
    chk(!mem_rd, "R8", "rd low at done", mem_rd, 0);
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    chk(!mem_rd, poke ? "R9" : "R8", "idle after done", mem_rd, 0);
  endtask

  initial begin
    repeat (CLK_P * 20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h1EAF);
    repeat (3) @(negedge clk);
    chk(!mem_rd && !done && data_out == 8'h00 && cycles == 3'd0 && pc_out == 16'h0,
        "R1", "reset outputs", {mem_rd, done, cycles}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_instr(16'h0200, 8'hF0, 8'h03, 8'h2A, 0, "R5");   // 031A then 041A
    run_instr(16'h0200, 8'hF0, 8'h03, 8'h02, 0, "R4");   // 03F2
    run_instr(16'h03FE, 8'h10, 8'h05, 8'h20, 0, "R6");
    run_instr(16'h03FF, 8'h80, 8'h05, 8'h70, 0, "R6");
    run_instr(16'hFFFE, 8'h80, 8'h05, 8'h90, 0, "R6");
    run_instr(16'h0400, 8'hF0, 8'hFF, 8'h20, 0, "R10");
    run_instr(16'h0300, 8'hFF, 8'h12, 8'h00, 0, "R4");
    run_instr(16'h0300, 8'hFF, 8'h12, 8'h01, 0, "R5");
    run_instr(16'h0500, 8'hF0, 8'h03, 8'h2A, 1, "R9");
    run_instr(16'h0500, 8'h10, 8'h03, 8'h02, 1, "R9");
    for (int i = 0; i < 60; i++)
      run_instr(16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                bit'($urandom % 4 == 0), "R4/R5");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule